// File: doc/BRIEF.md
# Conversion Result Buffer Bank

This block sits between an analog-to-digital converter's result path and the system bus. It keeps the most recent conversion result for each of eight input channels, and one more result slot reserved for the exceptional single-channel measurement. Each slot tracks whether its contents are unread and whether a newer result collided with unread data. A per-slot policy bit decides what happens on such a collision: the new result replaces the old one, or it is dropped so that the unread value is preserved.

Raw results arrive as 12-bit samples with a strobe and a channel number. Each channel has a width bit that reduces the sample to its top 10 bits or its top 8 bits before storage. The block also gathers ten interrupt sources: one per channel, one for the exceptional single-channel result and one for the end of an exceptional sequence. It keeps a sticky status bit for each source and an enable mask. A write-one-to-clear register clears status bits, and a single interrupt line is raised while any enabled status bit is set.

The converter, the channel sequencer and the trigger logic are outside this block. They only drive the result strobe and the sequence-done pulse.

Top module: `conv_result_bank`

## Requirements
- R1: After reset every slot has result 0, valid 0, overrun 0 and policy 0 (overwrite). The width, status and enable registers are 0, `irq` is 0, and every address reads 0.
- R2: A result strobe for channel c (`res_exc`=0) stores the aligned result in slot c and sets its valid flag. For `res_exc`=1 the result goes to slot 8. The change is visible from the cycle after the strobe.
- R3: Width register (address 9) bit c selects the alignment for channel c. With 0, the stored result is raw[11:2] in bits 9:0. With 1, it is raw[11:4] in bits 7:0. All upper result bits are 0. A slot 8 result uses the width bit of the channel sent with it.
- R4: Reading slot address s (0..8) returns the result in bits 10:0, the policy in bit 16, valid in bit 17 and overrun in bit 18. `bus_rdata` updates one cycle after `bus_rd`. The read clears valid and overrun. Writing bit 16 of a slot address sets its policy.
- R5: In overwrite mode (policy 0), a result arriving while valid is set replaces the stored value and sets overrun.
- R6: In hold mode (policy 1), a result arriving while valid is set is discarded. The stored value stays unchanged and overrun is set.
- R7: When a read and a new result hit the same slot in the same cycle, the read returns the old contents. Afterwards the slot holds the new result with valid 1 and overrun 0.
- R8: Status register (address 10, read-only) bit c sets on every channel-c result strobe. Bit 8 sets on each slot 8 result, and bit 9 sets on a `seq_done` pulse.
- R9: Writing address 12 clears every status bit written as 1. If a set event for the same bit happens in the same cycle, the bit stays set. Address 12 reads 0.
- R10: `irq` is high exactly when some status bit and the matching enable bit (address 11, bits 9:0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_exc | input | 1 | Result belongs to the exceptional single-channel slot |
| res_chan | input | 3 | Channel that produced the result |
| res_raw | input | 12 | Raw converter sample |
| seq_done | input | 1 | End-of-exceptional-sequence pulse |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `res_chan` always names an existing channel, and that every strobe is a single-cycle level sampled at the clock edge. The stimulus drives one bus operation per cycle at most, and takes channel numbers only from 0..7. It mixes result strobes, sequence pulses and bus operations in the same cycle, so that the read-versus-result and clear-versus-set collisions also occur at random and not only in the directed cases.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int RAW_W    = 12;
  localparam int RES_W    = 11;
  localparam int WIDE_W   = 10;
  localparam int NARROW_W = 8;
  localparam int BUS_W    = 32;
  localparam int POL_BIT  = 16;
  localparam int VLD_BIT  = 17;
  localparam int OVR_BIT  = 18;

  // keep the top bits of the raw sample, right-justified
  function automatic logic [RES_W-1:0] align_result(input logic [RAW_W-1:0] raw,
                                                    input logic narrow);
    logic [RAW_W-1:0] sh;
    sh = narrow ? (raw >> (RAW_W - NARROW_W)) : (raw >> (RAW_W - WIDE_W));
    return sh[RES_W-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] pack_slot(input logic [RES_W-1:0] data,
                                                 input logic hold,
                                                 input logic valid,
                                                 input logic ovr);
    logic [BUS_W-1:0] w;
    w = '0;
    w[RES_W-1:0] = data;
    w[POL_BIT]   = hold;
    w[VLD_BIT]   = valid;
    w[OVR_BIT]   = ovr;
    return w;
  endfunction
endpackage

// File: rtl/result_slot.sv
module result_slot
  import crb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_val,
  input  logic             rd_hit,
  input  logic             pol_we,
  input  logic             pol_d,
  output logic [RES_W-1:0] data_q,
  output logic             valid_q,
  output logic             ovr_q,
  output logic             hold_q,
  output logic             collide,
  output logic             drop
);
  logic occupied;

  assign occupied = valid_q & ~rd_hit;
  assign collide  = wr_en & occupied;
  assign drop     = collide & hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (wr_en) begin
      if (drop) begin
        ovr_q <= 1'b1;
      end else begin
        data_q  <= wr_val;
        valid_q <= 1'b1;
        ovr_q   <= occupied;
      end
    end else if (rd_hit) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (pol_we) hold_q <= pol_d;
  end

  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q); // R2
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_en) |=> (!valid_q && !ovr_q)); // R4
  AST_OVERWRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && valid_q && !rd_hit && !hold_q) |=> (ovr_q && valid_q)); // R5
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && valid_q && !rd_hit && hold_q) |=> ($stable(data_q) && ovr_q)); // R6
  AST_SAME_CYCLE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_hit) |=> (valid_q && !ovr_q)); // R7
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic [N_SRC-1:0] en_vec,
  output logic [N_SRC-1:0] status_q,
  output logic             irq
);
  logic [N_SRC-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign pending = status_q & en_vec;
  assign irq     = |pending;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R8
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
  import crb_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CH_W   = $clog2(N_CH),
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic              res_exc,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [RAW_W-1:0]  res_raw,
  input  logic              seq_done,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int N_BUF   = N_CH + 1;
  localparam int N_SRC   = N_CH + 2;
  localparam int EXC_IDX = N_CH;
  localparam int SEQ_IDX = N_CH + 1;
  localparam int A_WIDTH = N_CH + 1;
  localparam int A_STAT  = N_CH + 2;
  localparam int A_EN    = N_CH + 3;
  localparam int A_CLR   = N_CH + 4;

  logic [N_CH-1:0]  width_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;
  logic             narrow_sel;
  logic [RES_W-1:0] aligned;
  logic [BUS_W-1:0] rd_word;
  logic             unused_wdata;

  logic [N_BUF-1:0] res_hit, rd_hit, pol_we, valid_v, ovr_v, hold_v, collide_v, drop_v;
  logic [RES_W-1:0] data_v [N_BUF];

  assign unused_wdata = ^bus_wdata;
  assign narrow_sel   = width_q[res_chan];
  assign aligned      = align_result(res_raw, narrow_sel);

  generate
    for (genvar i = 0; i < N_BUF; i++) begin : g_slot
      if (i == EXC_IDX) begin : g_exc
        assign res_hit[i] = res_valid & res_exc;
      end else begin : g_ch
        assign res_hit[i] = res_valid & ~res_exc & (res_chan == CH_W'(i));
      end
      assign rd_hit[i] = bus_rd & (bus_addr == ADDR_W'(i));
      assign pol_we[i] = bus_wr & (bus_addr == ADDR_W'(i));

      result_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_hit[i]),
        .wr_val  (aligned),
        .rd_hit  (rd_hit[i]),
        .pol_we  (pol_we[i]),
        .pol_d   (bus_wdata[POL_BIT]),
        .data_q  (data_v[i]),
        .valid_q (valid_v[i]),
        .ovr_q   (ovr_v[i]),
        .hold_q  (hold_v[i]),
        .collide (collide_v[i]),
        .drop    (drop_v[i])
      );
    end
  endgenerate

  // every result strobe is an interrupt event for its slot
  assign set_vec = {seq_done, res_hit};
  assign clr_vec = (bus_wr && bus_addr == ADDR_W'(A_CLR)) ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      en_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_WIDTH)) width_q <= bus_wdata[N_CH-1:0];
      if (bus_addr == ADDR_W'(A_EN))    en_q    <= bus_wdata[N_SRC-1:0];
    end
  end

  irq_status #(.N_SRC(N_SRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .en_vec   (en_q),
    .status_q (status),
    .irq      (irq)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_BUF; i++) begin
      if (bus_addr == ADDR_W'(i))
        rd_word = pack_slot(data_v[i], hold_v[i], valid_v[i], ovr_v[i]);
    end
    if (bus_addr == ADDR_W'(A_WIDTH)) rd_word = BUS_W'(width_q);
    if (bus_addr == ADDR_W'(A_STAT))  rd_word = BUS_W'(status);
    if (bus_addr == ADDR_W'(A_EN))    rd_word = BUS_W'(en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && narrow_sel) |-> (aligned[RES_W-1:NARROW_W] == '0)); // R3
  AST_WIDE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (aligned[RES_W-1:WIDE_W] == '0)); // R3
  AST_ONE_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_hit)); // R2
  AST_DROP_ONLY_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((drop_v & ~collide_v) == '0)); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|set_vec) || $past(bus_wr && bus_addr == ADDR_W'(A_EN)))); // R10
endmodule

// File: tb/conv_result_bank_test.sv
`timescale 1ns/100ps
module conv_result_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 0, res_exc = 0, seq_done = 0, bus_rd = 0, bus_wr = 0;
  logic [2:0]  res_chan = 0;
  logic [11:0] res_raw = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  conv_result_bank uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_exc(res_exc),
    .res_chan(res_chan), .res_raw(res_raw), .seq_done(seq_done),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  logic [10:0] m_data [9];
  logic        m_val  [9];
  logic        m_ovr  [9];
  logic        m_hold [9];
  logic [7:0]  m_width;
  logic [9:0]  m_stat;
  logic [9:0]  m_en;

  function automatic logic [10:0] ref_align(input logic [11:0] raw, input logic narrow);
    if (narrow) return {3'b000, raw[11:4]};
    return {1'b0, raw[11:2]};
  endfunction

  function automatic logic [31:0] ref_read(input logic [3:0] a);
    logic [31:0] w;
    w = 32'h0;
    if (a < 4'd9) begin
      w[10:0] = m_data[a];
      w[16]   = m_hold[a];
      w[17]   = m_val[a];
      w[18]   = m_ovr[a];
    end else if (a == 4'd9)  w = {24'h0, m_width};
    else if (a == 4'd10)     w = {22'h0, m_stat};
    else if (a == 4'd11)     w = {22'h0, m_en};
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock cycle with all inputs given; model updated in hardware order
  task automatic cyc(input logic rd, input logic wr, input logic [3:0] a, input logic [31:0] wd,
                     input logic rv, input logic ex, input logic [2:0] ch, input logic [11:0] raw,
                     input logic sq, input string tag);
    logic [31:0] exp_rd;
    logic [10:0] al;
    logic [9:0]  setv, clrv;
    int b;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    res_valid = rv; res_exc = ex; res_chan = ch; res_raw = raw; seq_done = sq;
    exp_rd = ref_read(a);
    al = ref_align(raw, m_width[ch]);
    b = ex ? 8 : int'(ch);
    if (rd && a < 4'd9) begin
      m_val[a] = 1'b0;
      m_ovr[a] = 1'b0;
    end
    if (rv) begin
      if (m_hold[b] && m_val[b]) m_ovr[b] = 1'b1;
      else begin
        m_ovr[b]  = m_val[b];
        m_data[b] = al;
        m_val[b]  = 1'b1;
      end
    end
    clrv = 10'h0;
    if (wr) begin
      if (a < 4'd9)       m_hold[a] = wd[16];
      else if (a == 4'd9)  m_width = wd[7:0];
      else if (a == 4'd11) m_en = wd[9:0];
      else if (a == 4'd12) clrv = wd[9:0];
    end
    setv = 10'h0;
    if (rv) setv[b] = 1'b1;
    if (sq) setv[9] = 1'b1;
    m_stat = (m_stat & ~clrv) | setv;
    @(negedge clk);
    if (rd) check(tag, bus_rdata, exp_rd);
    check("R10 irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
    bus_rd = 0; bus_wr = 0; res_valid = 0; seq_done = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    cyc(0, 1, a, d, 0, 0, 0, 0, 0, "");
  endtask
  task automatic result(input logic ex, input logic [2:0] ch, input logic [11:0] raw);
    cyc(0, 0, 0, 0, 1, ex, ch, raw, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) begin
      m_data[i] = 0; m_val[i] = 0; m_ovr[i] = 0; m_hold[i] = 0;
    end
    m_width = 0; m_stat = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents of every address
    for (int a = 0; a < 16; a++) rd_reg(4'(a), "R1 reset read");
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2: store and read back, then R4 read clears valid
    result(0, 3'd3, 12'hABC);
    rd_reg(4'd3, "R2 stored result");
    check("R2 data field", {21'h0, m_data[3]}, 32'h2AF);
    rd_reg(4'd3, "R4 valid cleared by read");

    // R3: narrow width on channel 5, also for exceptional slot
    wr_reg(4'd9, 32'h20);
    result(0, 3'd5, 12'hFED);
    rd_reg(4'd5, "R3 narrow result");
    check("R3 narrow value", {21'h0, m_data[5]}, 32'hFE);
    result(1, 3'd5, 12'h123);
    rd_reg(4'd8, "R3 exceptional slot narrow");
    check("R3 exceptional value", {21'h0, m_data[8]}, 32'h12);
    rd_reg(4'd10, "R8 status bits 3 5 8");
    check("R8 status value", {22'h0, m_stat}, 32'h128);

    // R5: overwrite collision
    result(0, 3'd1, 12'h400);
    result(0, 3'd1, 12'h800);
    rd_reg(4'd1, "R5 overwrite with overrun");
    rd_reg(4'd1, "R4 overrun cleared by read");

    // R6: hold collision
    wr_reg(4'd2, 32'h1_0000);
    result(0, 3'd2, 12'h100);
    result(0, 3'd2, 12'h200);
    check("R6 held value", {21'h0, m_data[2]}, 32'h40);
    rd_reg(4'd2, "R6 hold keeps old with overrun");

    // R7: read and new result in the same cycle
    result(0, 3'd0, 12'h004);
    cyc(1, 0, 4'd0, 0, 1, 0, 3'd0, 12'h008, 0, "R7 read returns old");
    rd_reg(4'd0, "R7 new result kept, no overrun");

    // R9: clear all, then clear and set of the same bit together
    wr_reg(4'd12, 32'h3FF);
    rd_reg(4'd10, "R9 clear all");
    cyc(0, 1, 4'd12, 32'h10, 1, 0, 3'd4, 12'h555, 0, "");
    rd_reg(4'd10, "R9 set wins over clear");
    rd_reg(4'd12, "R9 clear register reads zero");

    // R8: sequence done; R10: enable gating
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    rd_reg(4'd10, "R8 sequence bit");
    wr_reg(4'd11, 32'h10);
    check("R10 irq enabled source", {31'h0, irq}, 32'h1);
    wr_reg(4'd12, 32'h10);
    check("R10 irq after clear", {31'h0, irq}, 32'h0);

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 3000; k++) begin
      logic rd, wr, rv, ex, sq;
      logic [3:0] a;
      logic [31:0] wd;
      int op;
      op = $urandom_range(0, 9);
      rd = (op < 4);
      wr = (op >= 4 && op < 7);
      a  = 4'($urandom_range(0, 15));
      if (op == 4) a = 4'd12;
      wd = $urandom;
      rv = ($urandom_range(0, 2) != 0);
      ex = ($urandom_range(0, 5) == 0);
      sq = ($urandom_range(0, 9) == 0);
      cyc(rd, wr, a, wd, rv, ex, 3'($urandom_range(0, 7)), 12'($urandom), sq,
          "R4 random read R5 R6 R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule